// File: doc/BRIEF.md
# Multi-Lane Memory Command Front End

This block sits on the user side of a memory controller whose logic runs at one quarter of the memory clock, so every user clock covers four memory-clock slots. Within one user clock it accepts a group of independent command lanes. The burst length sets how many lanes there are: burst 2 gives four lanes, burst 4 gives two, and burst 8 gives one. Each lane carries a 2-bit operation code, an address, a bank and, for writes, a data word with a byte mask. A lane may hold any mix of reads and writes to any location. Every lane keeps its own command FIFO and its own write-data FIFO, and each FIFO has four occupancy flags.

The downstream scheduler drains each lane in order. It reads the head entry off the issue port and pops it. When a read is issued, its `{bank, addr}` tag enters a per-lane tag FIFO. Read data comes back through a per-lane return strobe. The strobe retires the oldest tag and presents the data and that tag on the user read port one cycle later. Read results therefore leave each lane in issue order, even when the return latency varies.

Top module: `mcfe_front`

## Requirements
- R1: The lane count NL is 4, 2 or 1 for a BURST parameter of 2, 4 or 8. Each lane has separate queues, and traffic on one lane never changes another lane's flags, issue port or read port.
- R2: While `calib_done` is low, no command or write data is stored on any lane.
- R3: A lane stores a command only in a cycle with `cmd_en` and `calib_done` both high. Code 2'b01 (read) is stored as a read. Code 2'b00 (write) is stored only if that lane's `wr_en` bit is also high. Codes 2'b10 and 2'b11, a write code without `wr_en`, and `wr_en` alone all store nothing.
- R4: An accepted write stores its data, and its mask when DM_EN=1, in the lane's write-data FIFO. These appear on `issue_wdata`/`issue_wmask` while that write is at the head of the lane. With DM_EN=0, `issue_wmask` is all zeros.
- R5: A write offered to a full FIFO is dropped and leaves every stored entry unchanged. A write is accepted only if both its command FIFO and its write-data FIFO have room.
- R6: `issue_valid` is high while the lane's command FIFO holds an entry, except that a read at the head waits while the tag FIFO is full. `issue_is_rd` is 1 for a read. `issue_pop` with `issue_valid` removes exactly the head, and entries leave in the order they were accepted.
- R7: `ret_valid` on a lane with an outstanding read raises `rd_valid` on the next cycle. `rd_data` then carries the returned word and `rd_tag` carries `{bank, addr}` of the oldest outstanding read. `ret_valid` with no outstanding read is ignored.
- R8: The flags are registered and reflect the occupancy after each clock edge. full means occupancy equals DEPTH, almost-full means occupancy is at least DEPTH-2, empty means occupancy is 0, and almost-empty means occupancy is at most 2.
- R9: A synchronous active-high `rst` empties every FIFO. After reset, empty and almost-empty are set, full and almost-full are clear, and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst | input | 1 | Synchronous active-high reset |
| calib_done | input | 1 | Memory ready; gates all acceptance |
| cmd_en | input | 1 | Qualifies cmd, addr and bank on all lanes |
| cmd | input | 2*NL | Operation code per lane (00 write, 01 read) |
| addr | input | AW*NL | Address per lane |
| bank | input | BW*NL | Bank per lane |
| wr_en | input | NL | Write data/mask valid per lane |
| wr_data | input | DQW*BURST*NL | Write data per lane |
| wr_mask | input | DMW*BURST*NL | Write mask per lane |
| cmdq_empty | output | NL | Command FIFO empty |
| cmdq_aempty | output | NL | Command FIFO almost empty |
| cmdq_full | output | NL | Command FIFO full |
| cmdq_afull | output | NL | Command FIFO almost full |
| wdq_empty | output | NL | Write-data FIFO empty |
| wdq_aempty | output | NL | Write-data FIFO almost empty |
| wdq_full | output | NL | Write-data FIFO full |
| wdq_afull | output | NL | Write-data FIFO almost full |
| issue_pop | input | NL | Downstream takes the head entry |
| issue_valid | output | NL | Head entry available |
| issue_is_rd | output | NL | Head entry is a read |
| issue_addr | output | AW*NL | Head address |
| issue_bank | output | BW*NL | Head bank |
| issue_wdata | output | DQW*BURST*NL | Head write data |
| issue_wmask | output | DMW*BURST*NL | Head write mask |
| ret_valid | input | NL | Read return strobe per lane |
| ret_data | input | DQW*BURST*NL | Returned read data per lane |
| rd_valid | output | NL | Read result valid per lane |
| rd_data | output | DQW*BURST*NL | Read result data |
| rd_tag | output | (AW+BW)*NL | Bank and address of the completed read |

## Verification
The bench uses BURST=2, which gives four lanes, and DEPTH=8. At that depth, random traffic with rare pops fills each FIFO within a few cycles, so every flag threshold and the drop-on-full path are exercised. The tag FIFO also fills, which stalls reads at the head of a lane. A second copy built with DM_EN=0 receives the same stimulus, so the zeroed-mask variant is checked alongside the masked one.

// File: rtl/mcfe_pkg.sv
package mcfe_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_READ  = 2'b01,
    OP_RSV2  = 2'b10,
    OP_RSV3  = 2'b11
  } op_e;

  // lanes per user clock: four memory-clock slots divided by slots per burst
  function automatic int lanes_for_burst(input int burst);
    return (burst == 2) ? 4 : ((burst == 4) ? 2 : 1);
  endfunction

endpackage

// File: rtl/mcfe_fifo.sv
module mcfe_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         afull,
  output logic         empty,
  output logic         aempty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          push_ok, pop_ok;

  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign cnt_nxt = cnt + CW'(push_ok) - CW'(pop_ok);

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
      full   <= 1'b0;
      afull  <= 1'b0;
      empty  <= 1'b1;
      aempty <= 1'b1;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop_ok)  rp <= bump(rp);
      cnt    <= cnt_nxt;
      full   <= (cnt_nxt == CW'(DEPTH));
      afull  <= (cnt_nxt >= CW'(DEPTH - 2));
      empty  <= (cnt_nxt == '0);
      aempty <= (cnt_nxt <= CW'(2));
    end
  end

  assign dout = mem[rp];

endmodule

// File: rtl/mcfe_lane.sv
module mcfe_lane
  import mcfe_pkg::*;
#(
  parameter int AW    = 8,
  parameter int BW    = 2,
  parameter int DBW   = 8,
  parameter int MBW   = 2,
  parameter int DEPTH = 8,
  parameter int DM_EN = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept_en,
  input  logic [1:0]       op,
  input  logic [AW-1:0]    addr,
  input  logic [BW-1:0]    bank,
  input  logic             wr_en,
  input  logic [DBW-1:0]   wdata,
  input  logic [MBW-1:0]   wmask,
  output logic             cq_empty,
  output logic             cq_aempty,
  output logic             cq_full,
  output logic             cq_afull,
  output logic             wq_empty,
  output logic             wq_aempty,
  output logic             wq_full,
  output logic             wq_afull,
  input  logic             issue_pop,
  output logic             issue_valid,
  output logic             issue_is_rd,
  output logic [AW-1:0]    issue_addr,
  output logic [BW-1:0]    issue_bank,
  output logic [DBW-1:0]   issue_wdata,
  output logic [MBW-1:0]   issue_wmask,
  input  logic             ret_valid,
  input  logic [DBW-1:0]   ret_data,
  output logic             rd_valid,
  output logic [DBW-1:0]   rd_data,
  output logic [AW+BW-1:0] rd_tag
);
  localparam int CEW = 1 + BW + AW;
  localparam int TW  = AW + BW;

  logic           is_wr, is_rd, cmd_push, wd_push;
  logic [CEW-1:0] cmd_in, cmd_out;
  logic           head_rd, fire, wd_pop, tag_push, tag_pop;
  logic [TW-1:0]  tag_out;
  logic           tag_full, tag_empty, tag_afull_unused, tag_aempty_unused;

  assign is_wr    = (op_e'(op) == OP_WRITE) & wr_en;
  assign is_rd    = (op_e'(op) == OP_READ);
  assign cmd_push = accept_en & ((is_wr & ~wq_full) | is_rd);
  assign wd_push  = accept_en & is_wr & ~cq_full & ~wq_full;
  assign cmd_in   = {is_rd, bank, addr};

  mcfe_fifo #(.W(CEW), .DEPTH(DEPTH)) u_cmdq (
    .clk(clk), .rst(rst), .push(cmd_push), .din(cmd_in), .pop(fire),
    .dout(cmd_out), .full(cq_full), .afull(cq_afull),
    .empty(cq_empty), .aempty(cq_aempty)
  );

  assign head_rd     = cmd_out[CEW-1];
  assign issue_is_rd = head_rd;
  assign issue_bank  = cmd_out[AW +: BW];
  assign issue_addr  = cmd_out[AW-1:0];
  assign issue_valid = ~cq_empty & ~(head_rd & tag_full);
  assign fire        = issue_pop & issue_valid;
  assign wd_pop      = fire & ~head_rd;
  assign tag_push    = fire & head_rd;

  if (DM_EN != 0) begin : g_mask
    logic [DBW+MBW-1:0] wd_out;
    mcfe_fifo #(.W(DBW + MBW), .DEPTH(DEPTH)) u_wdq (
      .clk(clk), .rst(rst), .push(wd_push), .din({wmask, wdata}), .pop(wd_pop),
      .dout(wd_out), .full(wq_full), .afull(wq_afull),
      .empty(wq_empty), .aempty(wq_aempty)
    );
    assign issue_wdata = wd_out[DBW-1:0];
    assign issue_wmask = wd_out[DBW +: MBW];
  end else begin : g_nomask
    mcfe_fifo #(.W(DBW), .DEPTH(DEPTH)) u_wdq (
      .clk(clk), .rst(rst), .push(wd_push), .din(wdata), .pop(wd_pop),
      .dout(issue_wdata), .full(wq_full), .afull(wq_afull),
      .empty(wq_empty), .aempty(wq_aempty)
    );
    assign issue_wmask = '0;
  end

  // outstanding reads, oldest first
  mcfe_fifo #(.W(TW), .DEPTH(DEPTH)) u_tagq (
    .clk(clk), .rst(rst), .push(tag_push), .din({issue_bank, issue_addr}),
    .pop(tag_pop), .dout(tag_out), .full(tag_full), .afull(tag_afull_unused),
    .empty(tag_empty), .aempty(tag_aempty_unused)
  );

  assign tag_pop = ret_valid & ~tag_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_tag   <= '0;
    end else begin
      rd_valid <= tag_pop;
      if (tag_pop) begin
        rd_data <= ret_data;
        rd_tag  <= tag_out;
      end
    end
  end

endmodule

// File: rtl/mcfe_front.sv
module mcfe_front
  import mcfe_pkg::*;
#(
  parameter int BURST = 2,
  parameter int AW    = 8,
  parameter int BW    = 2,
  parameter int DQW   = 4,
  parameter int DMW   = 1,
  parameter int DEPTH = 8,
  parameter int DM_EN = 1,
  localparam int NL   = lanes_for_burst(BURST),
  localparam int DBW  = DQW * BURST,
  localparam int MBW  = DMW * BURST,
  localparam int TW   = AW + BW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              calib_done,
  input  logic              cmd_en,
  input  logic [2*NL-1:0]   cmd,
  input  logic [AW*NL-1:0]  addr,
  input  logic [BW*NL-1:0]  bank,
  input  logic [NL-1:0]     wr_en,
  input  logic [DBW*NL-1:0] wr_data,
  input  logic [MBW*NL-1:0] wr_mask,
  output logic [NL-1:0]     cmdq_empty,
  output logic [NL-1:0]     cmdq_aempty,
  output logic [NL-1:0]     cmdq_full,
  output logic [NL-1:0]     cmdq_afull,
  output logic [NL-1:0]     wdq_empty,
  output logic [NL-1:0]     wdq_aempty,
  output logic [NL-1:0]     wdq_full,
  output logic [NL-1:0]     wdq_afull,
  input  logic [NL-1:0]     issue_pop,
  output logic [NL-1:0]     issue_valid,
  output logic [NL-1:0]     issue_is_rd,
  output logic [AW*NL-1:0]  issue_addr,
  output logic [BW*NL-1:0]  issue_bank,
  output logic [DBW*NL-1:0] issue_wdata,
  output logic [MBW*NL-1:0] issue_wmask,
  input  logic [NL-1:0]     ret_valid,
  input  logic [DBW*NL-1:0] ret_data,
  output logic [NL-1:0]     rd_valid,
  output logic [DBW*NL-1:0] rd_data,
  output logic [TW*NL-1:0]  rd_tag
);
  logic accept_en;
  assign accept_en = cmd_en & calib_done;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    mcfe_lane #(
      .AW(AW), .BW(BW), .DBW(DBW), .MBW(MBW), .DEPTH(DEPTH), .DM_EN(DM_EN)
    ) u_lane (
      .clk(clk), .rst(rst), .accept_en(accept_en),
      .op(cmd[2*i +: 2]), .addr(addr[AW*i +: AW]), .bank(bank[BW*i +: BW]),
      .wr_en(wr_en[i]), .wdata(wr_data[DBW*i +: DBW]), .wmask(wr_mask[MBW*i +: MBW]),
      .cq_empty(cmdq_empty[i]), .cq_aempty(cmdq_aempty[i]),
      .cq_full(cmdq_full[i]), .cq_afull(cmdq_afull[i]),
      .wq_empty(wdq_empty[i]), .wq_aempty(wdq_aempty[i]),
      .wq_full(wdq_full[i]), .wq_afull(wdq_afull[i]),
      .issue_pop(issue_pop[i]), .issue_valid(issue_valid[i]),
      .issue_is_rd(issue_is_rd[i]), .issue_addr(issue_addr[AW*i +: AW]),
      .issue_bank(issue_bank[BW*i +: BW]), .issue_wdata(issue_wdata[DBW*i +: DBW]),
      .issue_wmask(issue_wmask[MBW*i +: MBW]),
      .ret_valid(ret_valid[i]), .ret_data(ret_data[DBW*i +: DBW]),
      .rd_valid(rd_valid[i]), .rd_data(rd_data[DBW*i +: DBW]),
      .rd_tag(rd_tag[TW*i +: TW])
    );
  end

endmodule

// File: rtl/mcfe_checker.sv
module mcfe_checker #(
  parameter int NL = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          calib_done,
  input logic [NL-1:0] cmdq_empty,
  input logic [NL-1:0] cmdq_aempty,
  input logic [NL-1:0] cmdq_full,
  input logic [NL-1:0] cmdq_afull,
  input logic [NL-1:0] wdq_empty,
  input logic [NL-1:0] wdq_aempty,
  input logic [NL-1:0] wdq_full,
  input logic [NL-1:0] wdq_afull,
  input logic [NL-1:0] issue_pop,
  input logic [NL-1:0] issue_valid,
  input logic [NL-1:0] ret_valid,
  input logic [NL-1:0] rd_valid
);
  for (genvar i = 0; i < NL; i++) begin : g_chk
    p_no_store_precal_r2: assert property (@(posedge clk) disable iff (rst)
      (!calib_done && cmdq_empty[i] && wdq_empty[i]) |=> (cmdq_empty[i] && wdq_empty[i]));
    p_wd_within_cmd_r4: assert property (@(posedge clk) disable iff (rst)
      cmdq_empty[i] |-> wdq_empty[i]);
    p_full_holds_r5: assert property (@(posedge clk) disable iff (rst)
      (cmdq_full[i] && !issue_pop[i]) |=> cmdq_full[i]);
    p_issue_has_entry_r6: assert property (@(posedge clk) disable iff (rst)
      issue_valid[i] |-> !cmdq_empty[i]);
    p_rd_after_ret_r7: assert property (@(posedge clk) disable iff (rst)
      rd_valid[i] |-> $past(ret_valid[i]));
    p_cmd_flags_r8: assert property (@(posedge clk) disable iff (rst)
      !(cmdq_full[i] && cmdq_empty[i]) && (!cmdq_full[i] || cmdq_afull[i])
      && (!cmdq_empty[i] || cmdq_aempty[i]));
    p_wd_flags_r8: assert property (@(posedge clk) disable iff (rst)
      !(wdq_full[i] && wdq_empty[i]) && (!wdq_full[i] || wdq_afull[i])
      && (!wdq_empty[i] || wdq_aempty[i]));
    p_reset_clears_r9: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (cmdq_empty[i] && wdq_empty[i] && !rd_valid[i] && !cmdq_full[i]));
  end
endmodule

bind mcfe_front mcfe_checker #(.NL(NL)) u_chk (
  .clk(clk), .rst(rst), .calib_done(calib_done),
  .cmdq_empty(cmdq_empty), .cmdq_aempty(cmdq_aempty),
  .cmdq_full(cmdq_full), .cmdq_afull(cmdq_afull),
  .wdq_empty(wdq_empty), .wdq_aempty(wdq_aempty),
  .wdq_full(wdq_full), .wdq_afull(wdq_afull),
  .issue_pop(issue_pop), .issue_valid(issue_valid),
  .ret_valid(ret_valid), .rd_valid(rd_valid)
);

// File: tb/mcfe_front_test.sv
module mcfe_front_test;
  localparam int BURST = 2, AW = 8, BW = 2, DQW = 4, DMW = 1, DEPTH = 8;
  localparam int NL = 4, DBW = DQW * BURST, MBW = DMW * BURST, TW = AW + BW;

  typedef struct packed {
    logic           rd;
    logic [BW-1:0]  bank;
    logic [AW-1:0]  addr;
    logic [DBW-1:0] data;
    logic [MBW-1:0] mask;
  } ent_t;

  logic clk = 0, rst = 1, calib_done = 0, cmd_en = 0;
  logic [2*NL-1:0] cmd = '0;
  logic [AW*NL-1:0] addr = '0;
  logic [BW*NL-1:0] bank = '0;
  logic [NL-1:0] wr_en = '0, issue_pop = '0, ret_valid = '0;
  logic [DBW*NL-1:0] wr_data = '0, ret_data = '0;
  logic [MBW*NL-1:0] wr_mask = '0;
  logic [NL-1:0] ce, cae, cf, caf, we, wae, wf, waf, iv, ir, rv;
  logic [AW*NL-1:0] ia;
  logic [BW*NL-1:0] ib;
  logic [DBW*NL-1:0] iw, rdd;
  logic [MBW*NL-1:0] im;
  logic [TW*NL-1:0] rt;
  logic [NL-1:0] n_ce, n_cae, n_cf, n_caf, n_we, n_wae, n_wf, n_waf, n_iv, n_ir, n_rv;
  logic [AW*NL-1:0] n_ia;
  logic [BW*NL-1:0] n_ib;
  logic [DBW*NL-1:0] n_iw, n_rdd;
  logic [MBW*NL-1:0] n_im;
  logic [TW*NL-1:0] n_rt;

  always #4 clk = ~clk;

  mcfe_front #(.BURST(BURST), .AW(AW), .BW(BW), .DQW(DQW), .DMW(DMW),
               .DEPTH(DEPTH), .DM_EN(1)) uut (
    .clk(clk), .rst(rst), .calib_done(calib_done), .cmd_en(cmd_en), .cmd(cmd),
    .addr(addr), .bank(bank), .wr_en(wr_en), .wr_data(wr_data), .wr_mask(wr_mask),
    .cmdq_empty(ce), .cmdq_aempty(cae), .cmdq_full(cf), .cmdq_afull(caf),
    .wdq_empty(we), .wdq_aempty(wae), .wdq_full(wf), .wdq_afull(waf),
    .issue_pop(issue_pop), .issue_valid(iv), .issue_is_rd(ir), .issue_addr(ia),
    .issue_bank(ib), .issue_wdata(iw), .issue_wmask(im), .ret_valid(ret_valid),
    .ret_data(ret_data), .rd_valid(rv), .rd_data(rdd), .rd_tag(rt));

  mcfe_front #(.BURST(BURST), .AW(AW), .BW(BW), .DQW(DQW), .DMW(DMW),
               .DEPTH(DEPTH), .DM_EN(0)) uut_nm (
    .clk(clk), .rst(rst), .calib_done(calib_done), .cmd_en(cmd_en), .cmd(cmd),
    .addr(addr), .bank(bank), .wr_en(wr_en), .wr_data(wr_data), .wr_mask(wr_mask),
    .cmdq_empty(n_ce), .cmdq_aempty(n_cae), .cmdq_full(n_cf), .cmdq_afull(n_caf),
    .wdq_empty(n_we), .wdq_aempty(n_wae), .wdq_full(n_wf), .wdq_afull(n_waf),
    .issue_pop(issue_pop), .issue_valid(n_iv), .issue_is_rd(n_ir), .issue_addr(n_ia),
    .issue_bank(n_ib), .issue_wdata(n_iw), .issue_wmask(n_im), .ret_valid(ret_valid),
    .ret_data(ret_data), .rd_valid(n_rv), .rd_data(n_rdd), .rd_tag(n_rt));

  int vectors = 0, fails = 0;
  bit done = 0;
  ent_t cq[NL][$];
  logic [TW-1:0] tq[NL][$];
  int wcnt[NL];
  logic exp_rv[NL];
  logic [DBW-1:0] exp_rd[NL];
  logic [TW-1:0] exp_tag[NL];
  logic [7:0] seq = 8'h10;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_issue(input int l);
    return (cq[l].size() > 0) && !(cq[l][0].rd && tq[l].size() == DEPTH);
  endfunction

  task automatic model_reset();
    for (int l = 0; l < NL; l++) begin
      cq[l].delete(); tq[l].delete(); wcnt[l] = 0; exp_rv[l] = 0;
    end
  endtask

  // R8 flags, R6 issue port, R7 read port, R4 data/mask, R1 per-lane separation
  task automatic check_all();
    for (int l = 0; l < NL; l++) begin
      int c = cq[l].size();
      check("R8", "cmd empty", ce[l], c == 0);
      check("R8", "cmd aempty", cae[l], c <= 2);
      check("R8", "cmd full", cf[l], c == DEPTH);
      check("R8", "cmd afull", caf[l], c >= DEPTH - 2);
      check("R8", "wd empty", we[l], wcnt[l] == 0);
      check("R8", "wd aempty", wae[l], wcnt[l] <= 2);
      check("R8", "wd full", wf[l], wcnt[l] == DEPTH);
      check("R8", "wd afull", waf[l], wcnt[l] >= DEPTH - 2);
      check("R1", "lane issue_valid", iv[l], exp_issue(l));
      if (exp_issue(l)) begin
        check("R6", "issue_is_rd", ir[l], cq[l][0].rd);
        check("R6", "issue_addr", ia[AW*l +: AW], cq[l][0].addr);
        check("R6", "issue_bank", ib[BW*l +: BW], cq[l][0].bank);
        if (!cq[l][0].rd) begin
          check("R4", "issue_wdata", iw[DBW*l +: DBW], cq[l][0].data);
          check("R4", "issue_wmask", im[MBW*l +: MBW], cq[l][0].mask);
          check("R4", "nomask wdata", n_iw[DBW*l +: DBW], cq[l][0].data);
          check("R4", "nomask wmask zero", n_im[MBW*l +: MBW], 0);
        end
      end
      check("R7", "rd_valid", rv[l], exp_rv[l]);
      if (exp_rv[l]) begin
        check("R7", "rd_data", rdd[DBW*l +: DBW], exp_rd[l]);
        check("R7", "rd_tag", rt[TW*l +: TW], exp_tag[l]);
      end
    end
  endtask

  // one cycle of random traffic; pop_pct and push on/off shape the phase
  task automatic step(input int pop_pct, input bit pushes, input int ret_pct);
    logic [NL-1:0] acc_rd, acc_wr, pops, rets;
    cmd_en = pushes && ($urandom % 100 < 80);
    for (int l = 0; l < NL; l++) begin
      cmd[2*l +: 2] = $urandom % 4;
      addr[AW*l +: AW] = $urandom;
      bank[BW*l +: BW] = $urandom;
      wr_en[l] = ($urandom % 100 < 70);
      wr_data[DBW*l +: DBW] = $urandom;
      wr_mask[MBW*l +: MBW] = $urandom;
      issue_pop[l] = exp_issue(l) && ($urandom % 100 < pop_pct);
      ret_valid[l] = ($urandom % 100 < ret_pct);
      ret_data[DBW*l +: DBW] = seq;
      seq = seq + 8'd1;
      acc_wr[l] = cmd_en && calib_done && cmd[2*l +: 2] == 2'b00 && wr_en[l]
                  && cq[l].size() < DEPTH && wcnt[l] < DEPTH;
      acc_rd[l] = cmd_en && calib_done && cmd[2*l +: 2] == 2'b01 && cq[l].size() < DEPTH;
      pops[l] = issue_pop[l];
      rets[l] = ret_valid[l] && tq[l].size() > 0;
    end
    @(posedge clk);
    for (int l = 0; l < NL; l++) begin
      ent_t e;
      exp_rv[l] = rets[l];
      if (rets[l]) begin
        exp_rd[l] = ret_data[DBW*l +: DBW];
        exp_tag[l] = tq[l].pop_front();
      end
      if (pops[l]) begin
        e = cq[l].pop_front();
        if (e.rd) tq[l].push_back({e.bank, e.addr});
        else wcnt[l]--;
      end
      if (acc_wr[l] || acc_rd[l]) begin
        e.rd = acc_rd[l];
        e.bank = bank[BW*l +: BW];
        e.addr = addr[AW*l +: AW];
        e.data = wr_data[DBW*l +: DBW];
        e.mask = wr_mask[MBW*l +: MBW];
        cq[l].push_back(e);
        if (acc_wr[l]) wcnt[l]++;
      end
    end
    @(negedge clk);
    check_all();
  endtask

  task automatic idle_inputs();
    cmd_en = 0; wr_en = '0; issue_pop = '0; ret_valid = '0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check_all();  // R9 reset state
    // R2: traffic before memory is ready stores nothing
    for (int k = 0; k < 30; k++) step(0, 1, 30);
    calib_done = 1;
    // R3: directed codes 10/11, write without wr_en, wr_en alone
    idle_inputs();
    cmd_en = 1;
    cmd = {2'b11, 2'b10, 2'b00, 2'b00};
    wr_en = 4'b0001;
    @(posedge clk);
    cq[0].push_back({1'b0, bank[0 +: BW], addr[0 +: AW], wr_data[0 +: DBW], wr_mask[0 +: MBW]});
    wcnt[0] = 1;
    @(negedge clk);
    check_all();
    check("R3", "lane1 write w/o wr_en dropped", ce[1], 1);
    check("R3", "lane2 code 10 dropped", ce[2], 1);
    check("R3", "lane3 code 11 dropped", ce[3], 1);
    cmd_en = 0; wr_en = 4'b1110;
    @(posedge clk);
    @(negedge clk);
    check("R3", "wr_en without cmd_en dropped", we[3:1], 3'b111);
    idle_inputs();
    // R5/R6/R7: fill (rare pops), mixed, drain
    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < 200; k++) step(5, 1, 20);
      for (int k = 0; k < 300; k++) step(50, 1, 50);
      for (int k = 0; k < 150; k++) step(95, 0, 70);
    end
    // R5: hold everything full, pushes keep coming, nothing changes
    for (int k = 0; k < 60; k++) step(0, 1, 0);
    for (int l = 0; l < NL; l++) check("R5", "full after saturation", cf[l], 1);
    for (int k = 0; k < 100; k++) step(90, 0, 60);
    // R9: synchronous reset in mid-traffic
    for (int k = 0; k < 20; k++) step(20, 1, 30);
    rst = 1;
    @(posedge clk);
    @(negedge clk);
    rst = 0;
    idle_inputs();
    model_reset();
    @(negedge clk);
    check_all();
    for (int l = 0; l < NL; l++) check("R9", "empty after reset", {ce[l], we[l], rv[l]}, 3'b110);
    for (int k = 0; k < 200; k++) step(40, 1, 40);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule